// File: doc/BRIEF.md
# Clock output power-management controller

This block decides, cycle by cycle, what each output of a clock generator does: four differential clock outputs and one single-ended reference output. It combines a power-good/power-down pin, one active-low enable pin per differential output, one register enable bit per output, a PLL-lock indication and an oscillator-valid indication. It also captures the serial-bus address-select strap once, when power-good is first seen high.

Every asynchronous control input passes through a synchronizer of `SYNC_STAGES` flops before it is used. A differential output's gate register may change only on a clock edge where the output clock level input is low. This keeps runt pulses off the pads. The decision for the reference output is combinational from registered state and is not delayed by that level.

Top module: `clkout_pm_ctrl`

## Requirements
- R1: While synchronized power-good is low, every `dif_run` bit becomes 0 on the next edge where `out_clk_lvl` is low, whatever the enable pins and enable bits are (0 = both legs driven low, 1 = running).
- R2: From reset until power-good is first seen high after synchronization, `ref_mode` is 2'b10 (high-impedance).
- R3: After that first sighting, `ref_mode` is 2'b00 (driven low) whenever synchronized power-good is low.
- R4: With power-good and lock high, an output whose enable bit is 1 and whose synchronized active-low pin is 0 runs (`dif_run` bit 1).
- R5: With power-good and lock high, an output whose enable bit is 1 and whose synchronized active-low pin is 1 is driven low.
- R6: An output whose enable bit is 0 is driven low whatever its pin level.
- R7: While synchronized PLL lock is low, every differential output is driven low.
- R8: On the edge where synchronized power-good is first high, `bus_addr` takes 7'b1101000 for strap 0 or 7'b1101010 for strap 1 (strap is bit 1), and `addr_valid` becomes 1. Later changes of the strap are ignored.
- R9: Once power-good has been seen, `ref_mode` is 2'b01 (running) while synchronized power-good and oscillator-valid are both high, independent of lock. It is 2'b00 when oscillator-valid is low.
- R10: Power-good, lock, oscillator-valid and the enable pins reach the decision logic through `SYNC_STAGES` flops. A `dif_run` bit changes only on an edge where `out_clk_lvl` is low, and holds while it is high.
- R11: `addr_valid`, `bus_addr` and the first-sighting state are cleared only by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Full asynchronous reset, active low |
| pwrgd_in | input | 1 | Power-good / power-down pin, asynchronous |
| oe_n_in | input | N_OUT | Active-low enable pins, one per differential output, asynchronous |
| en_bits | input | N_OUT | Register enable bits, one per differential output |
| pll_lock_in | input | 1 | PLL lock indication, asynchronous |
| osc_ok_in | input | 1 | Oscillator valid, asynchronous |
| addr_strap | input | 1 | Address-select strap |
| out_clk_lvl | input | 1 | Current level of the output clock, sampled in the clk domain |
| dif_run | output | N_OUT | Per differential output: 1 running, 0 both legs low |
| ref_mode | output | 2 | Reference output: 00 low, 01 running, 10 high-impedance |
| bus_addr | output | ADDR_W | Latched 7-bit bus address |
| addr_valid | output | 1 | Address latched / power-good seen since reset |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default 2. This exercises a synchronizer deeper than the minimum and shows whether the reference model's latency count follows the parameter. `N_OUT` stays at 4 and `GLITCH_FREE` stays at 1, so the low-phase gating is active. Pseudo-random output clock levels, together with a stretch held high, bring both the update edges and the hold cycles within reach. A second reset with the other strap value reaches both address encodings and the clearing of the sticky state.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
   typedef enum logic [1:0] {
      REF_LOW = 2'b00,
      REF_RUN = 2'b01,
      REF_HIZ = 2'b10
   } ref_mode_t;
endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkpm_strap.sv
module clkpm_strap #(
   parameter int                ADDR_W    = 7,
   parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h68,
   parameter int                STRAP_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pg_s,
   input  logic              strap,
   output logic              seen,
   output logic [ADDR_W-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= 1'b0;
         addr <= '0;
      end else if (pg_s && !seen) begin
         seen            <= 1'b1;
         addr            <= ADDR_BASE;
         addr[STRAP_BIT] <= strap;
      end
   end
endmodule

// File: rtl/clkpm_gate.sv
module clkpm_gate #(
   parameter int N_OUT       = 4,
   parameter bit GLITCH_FREE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_lvl,
   input  logic [N_OUT-1:0] want,
   output logic [N_OUT-1:0] run
);
   for (genvar i = 0; i < N_OUT; i++) begin : g_lane
      logic lane_q;
      if (GLITCH_FREE) begin : g_lowphase
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lane_q <= 1'b0;
            else if (!clk_lvl) lane_q <= want[i];
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= 1'b0;
            else        lane_q <= want[i];
         end
      end
      assign run[i] = lane_q;
   end
endmodule

// File: rtl/clkout_pm_ctrl.sv
module clkout_pm_ctrl
   import clkpm_pkg::*;
#(
   parameter int                N_OUT       = 4,
   parameter int                SYNC_STAGES = 2,
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] ADDR_BASE   = 7'h68,
   parameter int                STRAP_BIT   = 1,
   parameter bit                GLITCH_FREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrgd_in,
   input  logic [N_OUT-1:0]  oe_n_in,
   input  logic [N_OUT-1:0]  en_bits,
   input  logic              pll_lock_in,
   input  logic              osc_ok_in,
   input  logic              addr_strap,
   input  logic              out_clk_lvl,
   output logic [N_OUT-1:0]  dif_run,
   output logic [1:0]        ref_mode,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              addr_valid
);
   localparam int SYNC_W  = N_OUT + 3;
   localparam int PG_IDX  = N_OUT;
   localparam int LK_IDX  = N_OUT + 1;
   localparam int OSC_IDX = N_OUT + 2;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (N_OUT < 1) begin : g_chk_nout
      $error("N_OUT must be at least 1");
   end
   if (STRAP_BIT >= ADDR_W) begin : g_chk_bit
      $error("STRAP_BIT outside the address");
   end else if (ADDR_BASE[STRAP_BIT] != 1'b0) begin : g_chk_base
      $error("ADDR_BASE must have the strap bit clear");
   end

   logic [SYNC_W-1:0] raw_v;
   logic [SYNC_W-1:0] syn_v;
   logic [N_OUT-1:0]  oe_n_s;
   logic              pg_s;
   logic              lock_s;
   logic              osc_s;
   logic [N_OUT-1:0]  want;
   logic              seen;
   ref_mode_t         ref_d;

   assign raw_v = {osc_ok_in, pll_lock_in, pwrgd_in, oe_n_in};

   clkpm_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
   );

   assign oe_n_s = syn_v[N_OUT-1:0];
   assign pg_s   = syn_v[PG_IDX];
   assign lock_s = syn_v[LK_IDX];
   assign osc_s  = syn_v[OSC_IDX];

   // Output runs only with power good, lock, its bit set and its pin low.
   assign want = (pg_s && lock_s) ? (en_bits & ~oe_n_s) : '0;

   clkpm_gate #(.N_OUT(N_OUT), .GLITCH_FREE(GLITCH_FREE)) u_gate (
      .clk(clk), .rst_n(rst_n), .clk_lvl(out_clk_lvl), .want(want), .run(dif_run)
   );

   clkpm_strap #(.ADDR_W(ADDR_W), .ADDR_BASE(ADDR_BASE), .STRAP_BIT(STRAP_BIT)) u_strap (
      .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .strap(addr_strap),
      .seen(seen), .addr(bus_addr)
   );

   always_comb begin
      if (!seen)               ref_d = REF_HIZ;
      else if (pg_s && osc_s)  ref_d = REF_RUN;
      else                     ref_d = REF_LOW;
   end

   assign ref_mode   = ref_d;
   assign addr_valid = seen;
endmodule

// File: rtl/clkpm_chk.sv
module clkpm_chk #(
   parameter int                N_OUT       = 4,
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] ADDR_BASE   = 7'h68,
   parameter int                STRAP_BIT   = 1,
   parameter bit                GLITCH_FREE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_clk_lvl,
   input logic              pg_s,
   input logic              lock_s,
   input logic [N_OUT-1:0]  en_bits,
   input logic [N_OUT-1:0]  dif_run,
   input logic [1:0]        ref_mode,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              addr_valid
);
   localparam logic [ADDR_W-1:0] ADDR_ALT = ADDR_BASE | (ADDR_W'(1) << STRAP_BIT);

   // R1
   pg_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_clk_lvl && !pg_s) |=> (dif_run == '0));

   // R7
   lock_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_clk_lvl && !lock_s) |=> (dif_run == '0));

   // R6
   en_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_clk_lvl |=> ((dif_run & ~$past(en_bits)) == '0));

   // R10
   if (GLITCH_FREE) begin : g_hold
      high_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_clk_lvl |=> $stable(dif_run));
   end

   // R2
   hiz_before_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |-> (ref_mode == 2'b10));

   // R3
   no_hiz_after_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> (ref_mode != 2'b10));

   // R11
   seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> (addr_valid && $stable(bus_addr)));

   // R8
   addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> (bus_addr == ADDR_BASE || bus_addr == ADDR_ALT));
endmodule

bind clkout_pm_ctrl clkpm_chk #(
   .N_OUT(N_OUT), .ADDR_W(ADDR_W), .ADDR_BASE(ADDR_BASE),
   .STRAP_BIT(STRAP_BIT), .GLITCH_FREE(GLITCH_FREE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .out_clk_lvl(out_clk_lvl), .pg_s(pg_s),
   .lock_s(lock_s), .en_bits(en_bits), .dif_run(dif_run), .ref_mode(ref_mode),
   .bus_addr(bus_addr), .addr_valid(addr_valid)
);

// File: tb/sim_clkout_pm_ctrl.sv
`timescale 1ns/1ps
module sim_clkout_pm_ctrl;
   localparam int N  = 4;
   localparam int SS = 3;
   localparam int SW = N + 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pwrgd_in = 1'b0;
   logic [N-1:0] oe_n_in = '1;
   logic [N-1:0] en_bits = '1;
   logic         pll_lock_in = 1'b0;
   logic         osc_ok_in = 1'b0;
   logic         addr_strap = 1'b1;
   logic         out_clk_lvl = 1'b0;
   logic [N-1:0] dif_run;
   logic [1:0]   ref_mode;
   logic [6:0]   bus_addr;
   logic         addr_valid;

   int compared = 0;
   int mismatched = 0;
   bit rand_lvl = 1'b1;
   bit rand_pins = 1'b0;

   always #5 clk = ~clk;

   clkout_pm_ctrl #(.N_OUT(N), .SYNC_STAGES(SS)) u0 (
      .clk(clk), .rst_n(rst_n), .pwrgd_in(pwrgd_in), .oe_n_in(oe_n_in),
      .en_bits(en_bits), .pll_lock_in(pll_lock_in), .osc_ok_in(osc_ok_in),
      .addr_strap(addr_strap), .out_clk_lvl(out_clk_lvl), .dif_run(dif_run),
      .ref_mode(ref_mode), .bus_addr(bus_addr), .addr_valid(addr_valid)
   );

   // Reference model: a queue of raw input samples stands for the synchronizer delay.
   logic [SW-1:0] hist[$];
   logic [N-1:0]  m_run;
   bit            m_seen;
   logic [6:0]    m_addr;

   task automatic model_reset();
      hist.delete();
      for (int i = 0; i < SS; i++) hist.push_back('0);
      m_run  = '0;
      m_seen = 1'b0;
      m_addr = '0;
   endtask

   initial model_reset();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         logic [SW-1:0] cur;
         cur = hist[0];
         if (!out_clk_lvl) begin
            if (cur[N] && cur[N+1]) m_run = en_bits & ~cur[N-1:0];
            else                    m_run = '0;
         end
         if (!m_seen && cur[N]) begin
            m_seen = 1'b1;
            m_addr = addr_strap ? 7'b1101010 : 7'b1101000;
         end
         void'(hist.pop_front());
         hist.push_back({osc_ok_in, pll_lock_in, pwrgd_in, oe_n_in});
      end
   end

   function automatic logic [1:0] exp_ref();
      logic [SW-1:0] c;
      c = hist[0];
      if (!m_seen)             return 2'b10;
      else if (c[N] && c[N+2]) return 2'b01;
      else                     return 2'b00;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R1 R4 R5 R6 R7 R10 dif_run", 32'(dif_run), 32'(m_run));
         check("R2 R3 R9 ref_mode", 32'(ref_mode), 32'(exp_ref()));
         check("R8 R11 bus_addr", 32'(bus_addr), 32'(m_addr));
         check("R11 addr_valid", 32'(addr_valid), 32'(m_seen));
      end
   end

   // Background drivers, half a step after each falling edge.
   always @(negedge clk) begin
      #1;
      if (rand_lvl) out_clk_lvl <= 1'($urandom_range(0, 1));
      if (rand_pins) begin
         oe_n_in <= N'($urandom);
         en_bits <= N'($urandom);
      end
   end

   task automatic wait_cycles(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      wait_cycles(5);
      rst_n = 1'b1;
      wait_cycles(1);
      // R2: reset state, reference high-impedance, no address
      check("R2 reset ref_mode", 32'(ref_mode), 32'h2);
      check("R11 reset addr_valid", 32'(addr_valid), 32'h0);
      check("R1 reset dif_run", 32'(dif_run), 32'h0);

      // R1: power-good low, pins and bits changing
      rand_pins = 1'b1;
      wait_cycles(30);
      check("R1 pg low dif_run", 32'(dif_run), 32'h0);

      // R7 R9: power good with oscillator, no lock
      rand_pins = 1'b0;
      en_bits   = '1;
      oe_n_in   = '0;
      osc_ok_in = 1'b1;
      pwrgd_in  = 1'b1;
      wait_cycles(30);
      check("R7 no lock dif_run", 32'(dif_run), 32'h0);
      check("R9 ref runs without lock", 32'(ref_mode), 32'h1);
      check("R8 strap 1 address", 32'(bus_addr), 32'h6A);

      // R8: strap change ignored; R4 R5 R6 R10 under random pins and levels
      addr_strap  = 1'b0;
      pll_lock_in = 1'b1;
      wait_cycles(20);
      check("R4 all enabled running", 32'(dif_run), 32'hF);
      rand_pins = 1'b1;
      wait_cycles(300);
      check("R8 strap change ignored", 32'(bus_addr), 32'h6A);

      // R5 R6 directed: bit1/pin1 low, bit0 low
      rand_pins = 1'b0;
      en_bits   = 4'b1110;
      oe_n_in   = 4'b0100;
      wait_cycles(20);
      check("R5 R6 directed dif_run", 32'(dif_run), 32'b1010);

      // R10: level held high, changes must wait
      rand_lvl    = 1'b0;
      out_clk_lvl = 1'b1;
      en_bits     = '1;
      oe_n_in     = '0;
      wait_cycles(12);
      check("R10 hold while high", 32'(dif_run), 32'b1010);
      out_clk_lvl = 1'b0;
      wait_cycles(2);
      check("R10 update when low", 32'(dif_run), 32'hF);
      rand_lvl = 1'b1;

      // R9: oscillator invalid while power good
      osc_ok_in = 1'b0;
      wait_cycles(10);
      check("R9 osc invalid ref low", 32'(ref_mode), 32'h0);
      osc_ok_in = 1'b1;

      // R3 R1: power-good drops after first sighting
      pwrgd_in = 1'b0;
      rand_pins = 1'b1;
      wait_cycles(30);
      check("R3 ref low after seen", 32'(ref_mode), 32'h0);
      check("R1 pg dropped dif_run", 32'(dif_run), 32'h0);
      pwrgd_in = 1'b1;
      wait_cycles(200);

      // R11 R8: full reset clears the sticky state; strap 0 next
      rst_n    = 1'b0;
      pwrgd_in = 1'b0;
      wait_cycles(3);
      rst_n = 1'b1;
      wait_cycles(1);
      check("R11 cleared by reset", 32'(addr_valid), 32'h0);
      check("R2 hiz again after reset", 32'(ref_mode), 32'h2);
      pwrgd_in = 1'b1;
      wait_cycles(20);
      check("R8 strap 0 address", 32'(bus_addr), 32'h68);
      wait_cycles(100);
      finish_run();
   end
endmodule